// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This block carries out the 16-bit arithmetic instructions of a small 8-bit accumulator-style processor. It holds four 16-bit register pairs (BC, DE, HL and the stack pointer SP) and an 8-bit flag byte. When the execute strobe is high, it decodes a one-byte opcode into one of three operations: add a pair into HL, increment a pair, or decrement a pair. The chosen pair and the flag byte are updated at the next clock edge. Each instruction is one byte long, so the block looks only at the opcode byte and never at the byte that follows it.

A load port writes a single pair per cycle, and a separate strobe writes the flag byte. This is how the surrounding core, or a bench, puts the state into a known value. All four pairs and the flag byte are driven straight out of the block. An opcode outside the supported set changes nothing and raises a one-cycle illegal-opcode pulse.

Top module: `pair_arith_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, all four pairs read 0x0000, the flag byte reads 0x00 and the illegal output is low.
- R2: With load_en high and exec_en low, the pair picked by load_sel (0 = BC, 1 = DE, 2 = HL, 3 = SP) takes load_data at the next edge. With flag_load_en high and exec_en low, the flag byte takes flag_load_data with bits 3:0 forced to zero.
- R3: Opcodes 0x09, 0x19, 0x29 and 0x39 add BC, DE, HL and SP into HL, modulo 2^16. Examples: HL plus itself turns 0x2244 into 0x4488, and 0xFFFF + 0x0002 gives 0x0001.
- R4: The flag byte is laid out as Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. After an add into HL, H is the carry out of bit 11, C is the carry out of bit 15, N is 0 and Z keeps its previous value.
- R5: Opcodes 0x03, 0x13, 0x23 and 0x33 add one to BC, DE, HL and SP respectively, and 0xFFFF wraps to 0x0000.
- R6: Opcodes 0x0B, 0x1B, 0x2B and 0x3B subtract one from BC, DE, HL and SP respectively, and 0x0000 wraps to 0xFFFF.
- R7: Increment and decrement leave all eight bits of the flag byte unchanged. For example, 0xA0 still reads 0xA0 afterwards.
- R8: Any other opcode, executed, changes no pair and no flag. It raises illegal_o in the cycle after the strobe only, and illegal_o is low at all other times.
- R9: When exec_en is high, load_en and flag_load_en in the same cycle are ignored, and only the instruction takes effect.
- R10: Flag bits 3:0 always read zero.
- R11: With all three strobes low, every pair and the flag byte keep their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_en_i | input | 1 | Write load_data_i into the pair picked by load_sel_i |
| load_sel_i | input | 2 | Pair index for the load port (0 BC, 1 DE, 2 HL, 3 SP) |
| load_data_i | input | 16 | Value for the load port |
| flag_load_en_i | input | 1 | Write flag_load_data_i into the flag byte |
| flag_load_data_i | input | 8 | Value for the flag byte (bits 3:0 dropped) |
| exec_en_i | input | 1 | Execute the opcode on opcode_i this cycle |
| opcode_i | input | 8 | Instruction byte |
| bc_o | output | 16 | Pair BC |
| de_o | output | 16 | Pair DE |
| hl_o | output | 16 | Pair HL |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 8 | Flag byte {Z,N,H,C,0000} |
| illegal_o | output | 1 | One-cycle pulse after an unsupported opcode |

## Verification
All 256 opcode values are executed against four different register presets. This separates the twelve supported encodings from every illegal one, and it checks that each opcode writes only its own destination pair. The presets include values that carry only out of bit 11, only out of bit 15, both, or neither, so that the H and C flags are each tested on their own. Other presets sit exactly on the wrap points 0xFFFF and 0x0000 for increment and decrement. Flag presets include set low-nibble bits and a set Z bit, to show that padding is dropped and that Z is kept. Strobe collisions and idle cycles are run last to check the priority of execute over load and the hold behaviour.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;

    localparam int PAIR_W    = 16;
    localparam int OPC_W     = 8;
    localparam int NUM_PAIRS = 4;
    localparam int SEL_W     = 2;
    localparam int FN_W      = 4;
    localparam int FLAG_W    = 8;

    // flag bit positions inside the flag byte
    localparam int FLG_Z = 7;
    localparam int FLG_N = 6;
    localparam int FLG_H = 5;
    localparam int FLG_C = 4;

    localparam logic [FLAG_W-1:0] FLAG_LIVE_MASK = 8'hF0;

    // low-nibble function codes
    localparam logic [FN_W-1:0] FN_ADD = 4'h9;
    localparam logic [FN_W-1:0] FN_INC = 4'h3;
    localparam logic [FN_W-1:0] FN_DEC = 4'hB;

    localparam logic [SEL_W-1:0] SEL_HL = 2'd2;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_ADD,
        OPK_INC,
        OPK_DEC
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [SEL_W-1:0] sel;
        logic             illegal;
    } dec_t;

endpackage

// File: rtl/pair_op_decode.sv
module pair_op_decode
    import pair_arith_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output dec_t             dec_o
);

    localparam int HI_LSB = FN_W + SEL_W;

    logic hi_clear;

    assign hi_clear = (opcode_i[OPC_W-1:HI_LSB] == '0);

    always_comb begin
        dec_o.sel  = opcode_i[HI_LSB-1:FN_W];
        dec_o.kind = OPK_NONE;
        if (hi_clear) begin
            unique case (opcode_i[FN_W-1:0])
                FN_ADD:  dec_o.kind = OPK_ADD;
                FN_INC:  dec_o.kind = OPK_INC;
                FN_DEC:  dec_o.kind = OPK_DEC;
                default: dec_o.kind = OPK_NONE;
            endcase
        end
        dec_o.illegal = (dec_o.kind == OPK_NONE);
    end

    always_comb begin
        AST_DEC_LEGAL_SHAPE: assert (dec_o.illegal || hi_clear); // R8
    end

endmodule

// File: rtl/pair_addsub.sv
module pair_addsub
    import pair_arith_pkg::*;
#(
    parameter int W      = PAIR_W,
    parameter int HALF_W = W - 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  op_kind_e     kind_i,
    output logic [W-1:0] res_o,
    output logic         half_o,
    output logic         carry_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [HALF_W:0] lo_sum;
    logic [W:0]      full_sum;

    assign lo_sum   = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]};
    assign full_sum = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        res_o   = a_i;
        half_o  = 1'b0;
        carry_o = 1'b0;
        unique case (kind_i)
            OPK_ADD: begin
                res_o   = full_sum[W-1:0];
                half_o  = lo_sum[HALF_W];
                carry_o = full_sum[W];
            end
            OPK_INC: res_o = a_i + ONE;
            OPK_DEC: res_o = a_i - ONE;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/pair_flag_merge.sv
module pair_flag_merge
    import pair_arith_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  op_kind_e          kind_i,
    input  logic              half_i,
    input  logic              carry_i,
    output logic [FLAG_W-1:0] flags_o
);

    logic is_add;

    assign is_add = (kind_i == OPK_ADD);

    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        if (!FLAG_LIVE_MASK[b]) begin : g_pad
            assign flags_o[b] = 1'b0;
        end else if (b == FLG_N) begin : g_n
            assign flags_o[b] = is_add ? 1'b0 : flags_i[b];
        end else if (b == FLG_H) begin : g_h
            assign flags_o[b] = is_add ? half_i : flags_i[b];
        end else if (b == FLG_C) begin : g_c
            assign flags_o[b] = is_add ? carry_i : flags_i[b];
        end else begin : g_keep
            assign flags_o[b] = flags_i[b];
        end
    end

endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
    import pair_arith_pkg::*;
#(
    parameter int DATA_W = PAIR_W,
    parameter int HALF_W = DATA_W - 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_en_i,
    input  logic [SEL_W-1:0]  load_sel_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              flag_load_en_i,
    input  logic [FLAG_W-1:0] flag_load_data_i,
    input  logic              exec_en_i,
    input  logic [OPC_W-1:0]  opcode_i,
    output logic [DATA_W-1:0] bc_o,
    output logic [DATA_W-1:0] de_o,
    output logic [DATA_W-1:0] hl_o,
    output logic [DATA_W-1:0] sp_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              illegal_o
);

    typedef struct packed {
        logic [NUM_PAIRS-1:0][DATA_W-1:0] pairs;
        logic [FLAG_W-1:0]                flags;
        logic                             illegal;
    } state_t;

    state_t st_d, st_q;

    dec_t              dec;
    logic [DATA_W-1:0] opnd_a, opnd_b, alu_res;
    logic              alu_half, alu_carry;
    logic [SEL_W-1:0]  dest_sel;
    logic [FLAG_W-1:0] flags_next;

    pair_op_decode u_dec (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    // add: HL + pair; inc/dec: the pair itself
    assign opnd_b   = st_q.pairs[dec.sel];
    assign opnd_a   = (dec.kind == OPK_ADD) ? st_q.pairs[SEL_HL] : opnd_b;
    assign dest_sel = (dec.kind == OPK_ADD) ? SEL_HL : dec.sel;

    pair_addsub #(
        .W      (DATA_W),
        .HALF_W (HALF_W)
    ) u_addsub (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .kind_i  (dec.kind),
        .res_o   (alu_res),
        .half_o  (alu_half),
        .carry_o (alu_carry)
    );

    pair_flag_merge u_flags (
        .flags_i (st_q.flags),
        .kind_i  (dec.kind),
        .half_i  (alu_half),
        .carry_i (alu_carry),
        .flags_o (flags_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        if (exec_en_i) begin
            if (dec.illegal) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.pairs[dest_sel] = alu_res;
                st_d.flags           = flags_next;
            end
        end else begin
            if (load_en_i) begin
                st_d.pairs[load_sel_i] = load_data_i;
            end
            if (flag_load_en_i) begin
                st_d.flags = flag_load_data_i & FLAG_LIVE_MASK;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bc_o      = st_q.pairs[0];
    assign de_o      = st_q.pairs[1];
    assign hl_o      = st_q.pairs[2];
    assign sp_o      = st_q.pairs[3];
    assign flags_o   = st_q.flags;
    assign illegal_o = st_q.illegal;

    // ---------------- assertions ----------------
    AST_FLAG_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[3:0] == '0); // R10

    AST_ADD_N_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_en_i && dec.kind == OPK_ADD |=>
        !flags_o[FLG_N] && flags_o[FLG_Z] == $past(flags_o[FLG_Z])); // R4

    AST_INCDEC_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_en_i && (dec.kind == OPK_INC || dec.kind == OPK_DEC) |=> $stable(flags_o)); // R7

    AST_INC_HL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_en_i && dec.kind == OPK_INC && dec.sel == SEL_HL |=>
        hl_o == DATA_W'($past(hl_o) + 1'b1)); // R5

    AST_DEC_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_en_i && dec.kind == OPK_DEC && dec.sel == 2'd3 |=>
        sp_o == DATA_W'($past(sp_o) - 1'b1)); // R6

    AST_ILLEGAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_en_i && dec.illegal |=> illegal_o); // R8

    AST_ILLEGAL_ONLY_AFTER_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exec_en_i |=> !illegal_o); // R8

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exec_en_i && dec.illegal |=>
        $stable(bc_o) && $stable(de_o) && $stable(hl_o) && $stable(sp_o) && $stable(flags_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exec_en_i && !load_en_i && !flag_load_en_i |=>
        $stable(bc_o) && $stable(de_o) && $stable(hl_o) && $stable(sp_o) && $stable(flags_o)); // R11

endmodule

// File: tb/pair_arith_unit_tb.sv
module pair_arith_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic [1:0]  load_sel;
    logic [15:0] load_data;
    logic        flag_load_en;
    logic [7:0]  flag_load_data;
    logic        exec_en;
    logic [7:0]  opcode;
    logic [15:0] bc, de, hl, sp;
    logic [7:0]  flags;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m [4];
    logic [7:0]  mf;

    always #2 clk = ~clk;

    pair_arith_unit u_dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .load_en_i        (load_en),
        .load_sel_i       (load_sel),
        .load_data_i      (load_data),
        .flag_load_en_i   (flag_load_en),
        .flag_load_data_i (flag_load_data),
        .exec_en_i        (exec_en),
        .opcode_i         (opcode),
        .bc_o             (bc),
        .de_o             (de),
        .hl_o             (hl),
        .sp_o             (sp),
        .flags_o          (flags),
        .illegal_o        (illegal)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(string ptag, string ftag);
        chk(ptag, "BC", {16'h0, bc}, {16'h0, m[0]});
        chk(ptag, "DE", {16'h0, de}, {16'h0, m[1]});
        chk(ptag, "HL", {16'h0, hl}, {16'h0, m[2]});
        chk(ptag, "SP", {16'h0, sp}, {16'h0, m[3]});
        chk(ftag, "flags", {24'h0, flags}, {24'h0, mf});
    endtask

    task automatic load_pair(int idx, logic [15:0] v);
        @(negedge clk);
        load_en   = 1'b1;
        load_sel  = idx[1:0];
        load_data = v;
        @(negedge clk);
        load_en   = 1'b0;
        m[idx]    = v;
    endtask

    task automatic load_flags(logic [7:0] v);
        @(negedge clk);
        flag_load_en   = 1'b1;
        flag_load_data = v;
        @(negedge clk);
        flag_load_en   = 1'b0;
        mf             = v & 8'hF0;
    endtask

    task automatic preset(logic [15:0] b, logic [15:0] d, logic [15:0] h,
                          logic [15:0] s, logic [7:0] f);
        load_pair(0, b);
        load_pair(1, d);
        load_pair(2, h);
        load_pair(3, s);
        load_flags(f);
    endtask

    // updates the model for one opcode and returns tags and illegal expectation
    task automatic model_op(logic [7:0] op, output string ptag, output string ftag,
                            output logic exp_ill);
        int          sel;
        logic [16:0] full;
        logic [12:0] lo;
        sel     = int'(op[5:4]);
        exp_ill = 1'b1;
        ptag    = "R8";
        ftag    = "R8";
        if (op[7:6] == 2'b00) begin
            if (op[3:0] == 4'h9) begin
                full    = {1'b0, m[2]} + {1'b0, m[sel]};
                lo      = {1'b0, m[2][11:0]} + {1'b0, m[sel][11:0]};
                m[2]    = full[15:0];
                mf      = {mf[7], 1'b0, lo[12], full[16], 4'h0};
                exp_ill = 1'b0;
                ptag    = "R3";
                ftag    = "R4";
            end else if (op[3:0] == 4'h3) begin
                m[sel]  = m[sel] + 16'd1;
                exp_ill = 1'b0;
                ptag    = "R5";
                ftag    = "R7";
            end else if (op[3:0] == 4'hB) begin
                m[sel]  = m[sel] - 16'd1;
                exp_ill = 1'b0;
                ptag    = "R6";
                ftag    = "R7";
            end
        end
    endtask

    task automatic run_op(logic [7:0] op);
        string ptag, ftag;
        logic  exp_ill;
        model_op(op, ptag, ftag, exp_ill);
        @(negedge clk);
        opcode  = op;
        exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
        check_state(ptag, ftag);
        chk("R8", "illegal pulse", {31'h0, illegal}, {31'h0, exp_ill});
        @(negedge clk);
        chk("R8", "illegal drops", {31'h0, illegal}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n          = 1'b0;
        load_en        = 1'b0;
        load_sel       = 2'd0;
        load_data      = 16'h0;
        flag_load_en   = 1'b0;
        flag_load_data = 8'h0;
        exec_en        = 1'b0;
        opcode         = 8'h00;
        for (int i = 0; i < 4; i++) m[i] = 16'h0;
        mf = 8'h00;

        // R1: reset state, in reset and just after release
        repeat (3) @(negedge clk);
        check_state("R1", "R1");
        chk("R1", "illegal in reset", {31'h0, illegal}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1", "R1");
        chk("R1", "illegal after reset", {31'h0, illegal}, 32'h0);

        // R2 / R10: loads, with padding bits in the flag value
        preset(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 8'hAF);
        check_state("R2", "R2");
        chk("R10", "flag pad", {28'h0, flags[3:0]}, 32'h0);

        // R3: directed examples
        preset(16'h0000, 16'h0000, 16'h2244, 16'h0000, 8'h00);
        run_op(8'h29);
        chk("R3", "HL doubled", {16'h0, hl}, 32'h4488);
        preset(16'h0002, 16'h0000, 16'hFFFF, 16'h0000, 8'h00);
        run_op(8'h09);
        chk("R3", "HL wrap", {16'h0, hl}, 32'h0001);

        // R4: half carry only, carry only
        preset(16'h0000, 16'h0FFF, 16'hAAAA, 16'h0000, 8'hF0);
        run_op(8'h19);
        chk("R4", "H only", {24'h0, flags}, 32'h000000A0);
        preset(16'h0000, 16'h0000, 16'h8000, 16'hC000, 8'h60);
        run_op(8'h39);
        chk("R4", "C only", {24'h0, flags}, 32'h00000010);

        // R5 / R6 / R7: wrap points with flags 0xA0
        preset(16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 8'hA0);
        run_op(8'h03);
        chk("R5", "BC wrap", {16'h0, bc}, 32'h0);
        chk("R7", "flags after inc", {24'h0, flags}, 32'h000000A0);
        run_op(8'h3B);
        chk("R6", "SP wrap", {16'h0, sp}, 32'h0000FFFF);
        chk("R7", "flags after dec", {24'h0, flags}, 32'h000000A0);

        // sweep of every opcode over four presets
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 256; op++) begin
                case (s)
                    0: preset(16'h1122, 16'h0FFF, 16'hAAAA, 16'hC000, 8'hF0);
                    1: preset(16'h0001, 16'h0002, 16'hFFFF, 16'h0000, 8'h0F);
                    2: preset(16'hFFFF, 16'h2244, 16'h8000, 16'hC000, 8'hA0);
                    default: preset(16'h0000, 16'h0FFF, 16'h2244, 16'hFFFF, 8'h5A);
                endcase
                run_op(op[7:0]);
            end
        end

        // R9: execute wins over loads in the same cycle
        preset(16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'hB0);
        @(negedge clk);
        opcode         = 8'h03;
        exec_en        = 1'b1;
        load_en        = 1'b1;
        load_sel       = 2'd0;
        load_data      = 16'h5555;
        flag_load_en   = 1'b1;
        flag_load_data = 8'h00;
        @(negedge clk);
        exec_en        = 1'b0;
        load_en        = 1'b0;
        flag_load_en   = 1'b0;
        m[0]           = 16'h1001;
        check_state("R9", "R9");

        // R11: idle cycles with busy data inputs
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            load_data      = 16'hA5A5 ^ 16'(k);
            flag_load_data = 8'hFF;
            opcode         = 8'(k);
            load_sel       = k[1:0];
        end
        @(negedge clk);
        check_state("R11", "R11");

        finish_run();
    end

endmodule